// File: doc/BRIEF.md
# Predicated Single-Instruction Skip Controller

This block carries out conditional execution for a core whose branch instructions never redirect the program counter. A branch instruction only tests one condition against the current flags. If the condition is true, the next instruction runs normally. If it is false, a visible branch flag (`bf`) is raised and the next instruction is consumed without effect. The `suppress` output tells the execute stage to block every register, memory, flag and program-counter write of that instruction. The fetch logic works out how long the skipped instruction is. This block only tracks whether a skip is pending.

The controller is a two-state machine. `ST_RUN` is normal execution, with `bf` low. `ST_SKIP` means one instruction is being discarded, with `bf` and `suppress` high. There are two transitions. `T_ARM` goes from `ST_RUN` to `ST_SKIP` when a branch instruction retires and its condition fails. `T_DROP` goes from `ST_SKIP` back to `ST_RUN` when the next instruction retires, whatever kind it is. In every other cycle the state holds. An instruction retires at a rising clock edge where `ins_done` is high. `br_strobe` marks that retiring instruction as a branch and is only looked at together with `ins_done`.

Top module: `pskip_unit`

## Requirements
- R1: While reset is active, and after it is released, `bf` and `suppress` are 0 until a failing branch retires.
- R2: The condition code selects flags as follows. Code 0 is Z set and 1 is Z clear. Code 2 is C set and 3 is C clear. Code 4 is O set and 5 is O clear. Code 6 is S set and 7 is S clear. Code 8 is I set and 9 is I clear. The `flags` bit positions are Z=0, C=1, O=2, S=3, I=4.
- R3: When a branch retires in `ST_RUN` and its condition is true, `bf` stays 0 after that edge.
- R4: When a branch retires in `ST_RUN` and its condition is false, `bf` is 1 from the cycle after that edge.
- R5: `suppress` equals `bf` in every cycle, so it covers the whole skipped instruction.
- R6: In `ST_SKIP`, the first retiring instruction returns `bf` to 0 after its edge.
- R7: A branch that retires while `ST_SKIP` is active is skipped as a unit. It clears `bf` and does not re-arm it, even if its condition is false.
- R8: `br_strobe` or any condition input without `ins_done` has no effect on `bf`.
- R9: Codes 10 to 15 count as always true and never raise `bf`.
- R10: `bf` holds at 1 through any number of cycles without `ins_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_strobe | input | 1 | Retiring instruction is a branch |
| ins_done | input | 1 | An instruction retires at this edge |
| cond_code | input | CODE_W (4) | Branch condition selector |
| flags | input | NFLAG (5) | Current flags {I,S,O,C,Z} |
| bf | output | 1 | Branch flag: skip pending |
| suppress | output | 1 | Discard side effects of the current instruction |

## Verification
The bench builds the block with its default `CODE_W`=4 and `NFLAG`=5. With those values, all sixteen condition codes can be driven, including the six unused ones, and every flag can be tested true and false. Directed sequences arm and clear the skip. They place a failing branch inside a skip, stretch a skip over idle cycles, and strobe branches without retirement. Random traffic is then compared on every clock against a behavioural model.

// File: rtl/pskip_pkg.sv
package pskip_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SKIP = 1'b1
    } skip_state_e;
endpackage

// File: rtl/pskip_cond.sv
module pskip_cond #(
    parameter int CODE_W = 4,
    parameter int NFLAG  = 5
) (
    input  logic [CODE_W-1:0] code,
    input  logic [NFLAG-1:0]  flags,
    output logic              hit
);
    localparam int SEL_W = CODE_W - 1;

    logic [SEL_W-1:0] sel;
    logic             neg;

    assign sel = code[CODE_W-1:1];
    assign neg = code[0];

    // Even code tests a flag set, odd code tests it clear; unused selectors are true.
    always_comb begin
        hit = 1'b1;
        for (int i = 0; i < NFLAG; i++) begin
            if (int'(sel) == i) hit = flags[i] ^ neg;
        end
    end
endmodule

// File: rtl/pskip_fsm.sv
module pskip_fsm
    import pskip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic retire,
    input  logic arm_req,
    output logic bf,
    output logic suppress
);
    skip_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (retire && arm_req) state_d = ST_SKIP;  // T_ARM
            ST_SKIP: if (retire)            state_d = ST_RUN;   // T_DROP
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_SKIP: begin
                bf       = 1'b1;
                suppress = 1'b1;
            end
            default: begin
                bf       = 1'b0;
                suppress = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pskip_unit.sv
module pskip_unit #(
    parameter int CODE_W = 4,
    parameter int NFLAG  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_strobe,
    input  logic              ins_done,
    input  logic [CODE_W-1:0] cond_code,
    input  logic [NFLAG-1:0]  flags,
    output logic              bf,
    output logic              suppress
);
    logic cond_hit;
    logic arm_req;

    pskip_cond #(.CODE_W(CODE_W), .NFLAG(NFLAG)) u_cond (
        .code  (cond_code),
        .flags (flags),
        .hit   (cond_hit)
    );

    assign arm_req = br_strobe & ~cond_hit;

    pskip_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .retire   (ins_done),
        .arm_req  (arm_req),
        .bf       (bf),
        .suppress (suppress)
    );
endmodule

// File: rtl/pskip_unit_chk.sv
module pskip_unit_chk #(
    parameter int CODE_W = 4,
    parameter int NFLAG  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_strobe,
    input logic              ins_done,
    input logic [CODE_W-1:0] cond_code,
    input logic [NFLAG-1:0]  flags,
    input logic              bf,
    input logic              suppress
);
    logic ok;
    always_comb begin
        ok = 1'b1;
        if (int'(cond_code) < 2 * NFLAG)
            ok = flags[int'(cond_code) / 2] ^ cond_code[0];
    end

    a_r3_pass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!bf && ins_done && br_strobe && ok) |=> !bf);
    a_r4_fail_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (!bf && ins_done && br_strobe && !ok) |=> bf);
    a_r5_suppress_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        suppress == bf);
    a_r6_one_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bf && ins_done) |=> !bf);
    a_r8_no_retire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bf && !ins_done) |=> !bf);
    a_r9_unused_never_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!bf && ins_done && int'(cond_code) >= 2 * NFLAG) |=> !bf);
    a_r10_hold_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (bf && !ins_done) |=> bf);
endmodule

bind pskip_unit pskip_unit_chk #(.CODE_W(CODE_W), .NFLAG(NFLAG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_strobe (br_strobe),
    .ins_done  (ins_done),
    .cond_code (cond_code),
    .flags     (flags),
    .bf        (bf),
    .suppress  (suppress)
);

// File: tb/pskip_unit_tb.sv
module pskip_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       br_strobe = 1'b0;
    logic       ins_done = 1'b0;
    logic [3:0] cond_code = 4'd0;
    logic [4:0] flags = 5'd0;
    logic       bf, suppress;

    int errors = 0;
    int checks = 0;
    bit ref_bf = 1'b0;
    bit finished = 1'b0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    pskip_unit u_dut (
        .clk(clk), .rst_n(rst_n), .br_strobe(br_strobe), .ins_done(ins_done),
        .cond_code(cond_code), .flags(flags), .bf(bf), .suppress(suppress)
    );

    // Condition table written from R2/R9.
    function automatic bit cond_true(int code, logic [4:0] f);
        case (code)
            0: return f[0] == 1'b1;
            1: return f[0] == 1'b0;
            2: return f[1] == 1'b1;
            3: return f[1] == 1'b0;
            4: return f[2] == 1'b1;
            5: return f[2] == 1'b0;
            6: return f[3] == 1'b1;
            7: return f[3] == 1'b0;
            8: return f[4] == 1'b1;
            9: return f[4] == 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check_outputs();
        checks++;
        if (bf !== ref_bf) begin
            errors++;
            $display("FAIL %s: bf actual=%0b expected=%0b", cur_tag, bf, ref_bf);
        end
        checks++;
        if (suppress !== ref_bf) begin
            errors++;
            $display("FAIL R5 (%s): suppress actual=%0b expected=%0b", cur_tag, suppress, ref_bf);
        end
    endtask

    // Drive one cycle at negedge, compute expected state after the next edge.
    task automatic step(input bit br, input bit dn, input int code, input logic [4:0] f,
                        input string tag);
        bit nxt;
        @(negedge clk);
        check_outputs();
        br_strobe = br;
        ins_done  = dn;
        cond_code = 4'(code);
        flags     = f;
        cur_tag   = tag;
        nxt = ref_bf;
        if (dn) begin
            if (ref_bf) nxt = 1'b0;
            else if (br && !cond_true(code, f)) nxt = 1'b1;
        end
        @(posedge clk);
        if (rst_n) ref_bf = nxt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset, with a failing branch presented during reset
        step(1, 1, 0, 5'b00000, "R1");
        step(0, 0, 0, 5'b00000, "R1");
        rst_n = 1'b1;
        step(0, 0, 0, 5'b00000, "R1");

        // R2/R3/R4/R6: each code, failing then passing
        for (int c = 0; c < 10; c++) begin
            logic [4:0] fail_f;
            fail_f = (c % 2 == 0) ? 5'b00000 : 5'b11111;
            step(1, 1, c, fail_f, "R4");
            step(0, 1, 0, 5'b00000, "R6");
            step(1, 1, c, ~fail_f, "R3");
            step(0, 0, 0, 5'b00000, "R2");
        end
        // Negated sign: S clear runs, S set skips (R2)
        step(1, 1, 7, 5'b00000, "R2");
        step(1, 1, 7, 5'b01000, "R2");
        step(0, 1, 0, 5'b00000, "R6");
        // R7: failing branch inside a skip does not re-arm
        step(1, 1, 0, 5'b00000, "R4");
        step(1, 1, 0, 5'b00000, "R7");
        step(0, 0, 0, 5'b00000, "R7");
        // R10: hold across idle cycles, with branch strobes but no retire
        step(1, 1, 2, 5'b00000, "R4");
        for (int k = 0; k < 6; k++) step(1, 0, 2, 5'b00000, "R10");
        step(0, 1, 0, 5'b00000, "R6");
        // R8: strobe without retire from run state
        for (int k = 0; k < 4; k++) step(1, 0, k * 2, 5'b00000, "R8");
        // R9: unused codes never arm
        for (int c = 10; c < 16; c++) step(1, 1, c, 5'b00000, "R9");
        step(0, 0, 0, 5'b00000, "R9");
        // Random traffic
        for (int n = 0; n < 3000; n++)
            step(1'($urandom), 1'($urandom), int'($urandom_range(0, 15)),
                 5'($urandom), "R2");
        @(negedge clk);
        check_outputs();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule